// File: doc/BRIEF.md
# Switch Polling-Unit Bracketed Configuration Sequencer

This block carries out two management procedures on an Ethernet switch: bulk programming and soft reset. It uses an external indirect register access engine for every register access and drives no bus of its own. A request names a device address, a register number, a read/write flag and write data. The engine answers each request with a single response pulse that carries read data and an error flag. The entries to program come from an external table. The block presents an index, and the addressed entry appears on its inputs one clock later, as from a registered block RAM.

A program command first stops the switch's PHY polling unit. It reads the global control register, clears the polling-enable bit, writes the value back, and then polls the global status register until the unit reports it has stopped. It then writes the table entries in index order. Last, it sets the enable bit again with the same read-modify-write and polls until the unit reports it is running. This re-enable runs even when a table write has failed. A reset command reads control, writes a fixed word that sets software reset and polling enable, and then polls until the reset-in-progress pattern clears. The status reads of one poll are spaced by a cycle counter, and each poll has a limit on how many reads it makes.

While a command runs, `busy` is high. The command ends with a one-cycle `done` pulse, and `result` then holds 0 (success), 1 (transfer error) or 2 (poll limit reached).

Top module: `swcfg_seq`

## Requirements
- R1: After reset, `busy`, `done` and `req_valid` are 0, `result` is 0 and `tbl_idx` is 0.
- R2: A `start` seen while idle raises `busy`. The next cycle shows a read request to device 0x1B, register 0x04 (control). A `start` seen while busy is ignored and adds no requests.
- R3: For a program command, the control value read back is written to device 0x1B register 0x04 with bit 14 cleared and every other bit kept. Reads of device 0x1B register 0x00 (status) then repeat until status bits 15:14 are not both 1.
- R4: Table entries are written in index order from index 0. Each write goes to device `ent_port`, register `ent_reg`, with data `ent_value`. These are sampled two cycles after `tbl_idx` takes the entry's index.
- R5: After the last entry, control is read again and written back with bit 14 set. Status is then polled until bits 15:14 are both 1, and `result` is 0.
- R6: With an entry count of 0, no table write is issued and the enable step follows the disable step directly.
- R7: A table write answered with an error stops further table writes. The enable step still runs, and `result` is 1 whatever the enable step's outcome.
- R8: A poll whose condition is never met makes exactly MAX_POLLS status reads and ends with `result` 2. A failed disable poll issues no table writes and no enable step.
- R9: After a status response that does not meet the condition, the next status read request appears exactly GAP_CYCLES+2 cycles after that response.
- R10: A reset command reads control and then writes 0xC400 whatever value was read. It polls status until (status AND 0xC800) differs from 0xC800, and `result` is 0.
- R11: An error response to a control-register access ends the command at once with `result` 1, and no further request is issued.
- R12: `done` is a single-cycle pulse one cycle after the final response, with `busy` low in that cycle. `result` changes only together with `done`.
- R13: No request is issued while an earlier request still awaits its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command start pulse, taken only when idle |
| cmd_reset | input | 1 | 1 selects the reset command, 0 selects programming |
| entry_count | input | CNT_W | Number of table entries to write, 0..MAX_ENTRIES |
| tbl_idx | output | IDX_W | Index of the table entry being fetched |
| ent_port | input | 5 | Device address of the fetched entry |
| ent_reg | input | 5 | Register number of the fetched entry |
| ent_value | input | 16 | Write data of the fetched entry |
| req_valid | output | 1 | One-cycle request to the access engine |
| req_write | output | 1 | 1 for a write request, 0 for a read |
| req_dev | output | 5 | Device address of the request |
| req_reg | output | 5 | Register number of the request |
| req_wdata | output | 16 | Write data of the request |
| rsp_valid | input | 1 | One-cycle response from the access engine |
| rsp_err | input | 1 | Response reports a failed access |
| rsp_rdata | input | 16 | Read data of the response |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Completion code: 0 ok, 1 transfer error, 2 poll limit |

## Verification
Each result of this block is due a fixed number of cycles after the event that causes it. The first control read appears one cycle after `start` is sampled, and every follow-on request appears in the cycle after the response that triggers it. The exception is a repeated status read, which is due GAP_CYCLES+2 cycles after the response that did not meet the condition. A table write appears two cycles after its index is presented. `done` is due one cycle after the final response. The bench records the cycle of every response from its engine model and checks each request against the next expected item in the cycle the request appears. It also measures the response-to-request distance for repeated status reads and the response-to-`done` distance against these figures.

// File: rtl/swcfg_pkg.sv
package swcfg_pkg;

  localparam logic [4:0]  GLB_DEV    = 5'h1B;
  localparam logic [4:0]  CTL_REG    = 5'h04;
  localparam logic [4:0]  STS_REG    = 5'h00;
  localparam int          POLL_BIT   = 14;
  localparam logic [15:0] RESET_WORD = 16'hC400;
  localparam logic [15:0] RST_MASK   = 16'hC800;

  typedef enum logic [1:0] {
    RES_OK   = 2'd0,
    RES_XFER = 2'd1,
    RES_TMO  = 2'd2
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CRD,
    S_CWR,
    S_SRD,
    S_GAP,
    S_FETCH,
    S_LOAD,
    S_TWR
  } st_e;

  typedef enum logic [1:0] {
    P_DIS,
    P_EN,
    P_RST
  } ph_e;

endpackage

// File: rtl/swcfg_gap_timer.sv
module swcfg_gap_timer #(
  parameter int GAP_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic zero
);
  localparam int W = $clog2(GAP_CYCLES + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= W'(GAP_CYCLES);
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/swcfg_try_counter.sv
module swcfg_try_counter #(
  parameter int MAX_POLLS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int W = (MAX_POLLS > 2) ? $clog2(MAX_POLLS) : 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (inc)
      cnt <= cnt + 1'b1;
  end

  assign last = (cnt == W'(MAX_POLLS - 1));
endmodule

// File: rtl/swcfg_seq.sv
module swcfg_seq
  import swcfg_pkg::*;
#(
  parameter int MAX_ENTRIES = 16,
  parameter int MAX_POLLS   = 1000,
  parameter int GAP_CYCLES  = 100000,
  localparam int IDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cmd_reset,
  input  logic [CNT_W-1:0] entry_count,
  output logic [IDX_W-1:0] tbl_idx,
  input  logic [4:0]       ent_port,
  input  logic [4:0]       ent_reg,
  input  logic [15:0]      ent_value,
  output logic             req_valid,
  output logic             req_write,
  output logic [4:0]       req_dev,
  output logic [4:0]       req_reg,
  output logic [15:0]      req_wdata,
  input  logic             rsp_valid,
  input  logic             rsp_err,
  input  logic [15:0]      rsp_rdata,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result
);

  st_e              state;
  ph_e              phase;
  logic [CNT_W-1:0] cnt_q;
  logic             wr_failed;

  logic             cond_met;
  logic             poll_ok;
  logic             try_last;
  logic             try_clr;
  logic             retry;
  logic             gap_zero;
  logic [15:0]      ctl_next;
  logic             last_entry;

  // poll condition for the active phase
  always_comb begin
    unique case (phase)
      P_DIS:   cond_met = (rsp_rdata[15:14] != 2'b11);
      P_EN:    cond_met = (rsp_rdata[15:14] == 2'b11);
      default: cond_met = ((rsp_rdata & RST_MASK) != RST_MASK);
    endcase
  end

  // control word written back after the control read
  always_comb begin
    unique case (phase)
      P_DIS:   ctl_next = rsp_rdata & ~(16'h1 << POLL_BIT);
      P_EN:    ctl_next = rsp_rdata | (16'h1 << POLL_BIT);
      default: ctl_next = RESET_WORD;
    endcase
  end

  assign poll_ok    = !rsp_err && cond_met;
  assign try_clr    = (state == S_CWR) && rsp_valid && !rsp_err;
  assign retry      = (state == S_SRD) && rsp_valid && !poll_ok && !try_last;
  assign last_entry = ((CNT_W'(tbl_idx) + CNT_W'(1)) == cnt_q);

  swcfg_try_counter #(.MAX_POLLS(MAX_POLLS)) u_tries (
    .clk  (clk),
    .rst  (rst),
    .clr  (try_clr),
    .inc  (retry),
    .last (try_last)
  );

  swcfg_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk  (clk),
    .rst  (rst),
    .load (retry),
    .zero (gap_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      phase     <= P_DIS;
      cnt_q     <= '0;
      wr_failed <= 1'b0;
      tbl_idx   <= '0;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_dev   <= '0;
      req_reg   <= '0;
      req_wdata <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      result    <= RES_OK;
    end else begin
      req_valid <= 1'b0;
      done      <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            busy      <= 1'b1;
            wr_failed <= 1'b0;
            cnt_q     <= entry_count;
            phase     <= cmd_reset ? P_RST : P_DIS;
            req_valid <= 1'b1;
            req_write <= 1'b0;
            req_dev   <= GLB_DEV;
            req_reg   <= CTL_REG;
            state     <= S_CRD;
          end
        end

        S_CRD: begin
          if (rsp_valid) begin
            if (rsp_err) begin
              busy   <= 1'b0;
              done   <= 1'b1;
              result <= RES_XFER;
              state  <= S_IDLE;
            end else begin
              req_valid <= 1'b1;
              req_write <= 1'b1;
              req_dev   <= GLB_DEV;
              req_reg   <= CTL_REG;
              req_wdata <= ctl_next;
              state     <= S_CWR;
            end
          end
        end

        S_CWR: begin
          if (rsp_valid) begin
            if (rsp_err) begin
              busy   <= 1'b0;
              done   <= 1'b1;
              result <= RES_XFER;
              state  <= S_IDLE;
            end else begin
              req_valid <= 1'b1;
              req_write <= 1'b0;
              req_dev   <= GLB_DEV;
              req_reg   <= STS_REG;
              state     <= S_SRD;
            end
          end
        end

        S_SRD: begin
          if (rsp_valid) begin
            if (poll_ok) begin
              unique case (phase)
                P_DIS: begin
                  if (cnt_q == '0) begin
                    phase     <= P_EN;
                    req_valid <= 1'b1;
                    req_write <= 1'b0;
                    req_dev   <= GLB_DEV;
                    req_reg   <= CTL_REG;
                    state     <= S_CRD;
                  end else begin
                    tbl_idx <= '0;
                    state   <= S_FETCH;
                  end
                end
                default: begin
                  busy   <= 1'b0;
                  done   <= 1'b1;
                  result <= wr_failed ? RES_XFER : RES_OK;
                  state  <= S_IDLE;
                end
              endcase
            end else if (try_last) begin
              busy   <= 1'b0;
              done   <= 1'b1;
              result <= wr_failed ? RES_XFER : RES_TMO;
              state  <= S_IDLE;
            end else begin
              state <= S_GAP;
            end
          end
        end

        S_GAP: begin
          if (gap_zero) begin
            req_valid <= 1'b1;
            req_write <= 1'b0;
            req_dev   <= GLB_DEV;
            req_reg   <= STS_REG;
            state     <= S_SRD;
          end
        end

        S_FETCH: state <= S_LOAD;

        S_LOAD: begin
          req_valid <= 1'b1;
          req_write <= 1'b1;
          req_dev   <= ent_port;
          req_reg   <= ent_reg;
          req_wdata <= ent_value;
          state     <= S_TWR;
        end

        S_TWR: begin
          if (rsp_valid) begin
            if (rsp_err || last_entry) begin
              if (rsp_err) wr_failed <= 1'b1;
              phase     <= P_EN;
              req_valid <= 1'b1;
              req_write <= 1'b0;
              req_dev   <= GLB_DEV;
              req_reg   <= CTL_REG;
              state     <= S_CRD;
            end else begin
              tbl_idx <= tbl_idx + 1'b1;
              state   <= S_FETCH;
            end
          end
        end

        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/swcfg_seq_chk.sv
module swcfg_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       req_valid,
  input logic       rsp_valid,
  input logic [1:0] result
);
  logic outst;

  always_ff @(posedge clk) begin
    if (rst)
      outst <= 1'b0;
    else if (req_valid)
      outst <= 1'b1;
    else if (rsp_valid)
      outst <= 1'b0;
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  // R2
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> busy);

  // R13
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !outst);

endmodule

bind swcfg_seq swcfg_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .req_valid (req_valid),
  .rsp_valid (rsp_valid),
  .result    (result)
);

// File: tb/swcfg_seq_tb.sv
module swcfg_seq_tb;
  localparam int MAXE  = 8;
  localparam int MAXP  = 4;
  localparam int GAP   = 3;
  localparam int IW    = 3;
  localparam int CW    = 4;
  localparam int LAT   = 2;

  typedef struct packed {
    logic        wr;
    logic [4:0]  dev;
    logic [4:0]  rg;
    logic [15:0] data;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          cmd_reset = 1'b0;
  logic [CW-1:0] entry_count = '0;
  logic [IW-1:0] tbl_idx;
  logic [4:0]    ent_port;
  logic [4:0]    ent_reg;
  logic [15:0]   ent_value;
  logic          req_valid, req_write;
  logic [4:0]    req_dev, req_reg;
  logic [15:0]   req_wdata;
  logic          rsp_valid = 1'b0;
  logic          rsp_err = 1'b0;
  logic [15:0]   rsp_rdata = '0;
  logic          busy, done;
  logic [1:0]    result;

  always #5 clk = ~clk;

  swcfg_seq #(.MAX_ENTRIES(MAXE), .MAX_POLLS(MAXP), .GAP_CYCLES(GAP)) u_dut (
    .clk(clk), .rst(rst), .start(start), .cmd_reset(cmd_reset),
    .entry_count(entry_count), .tbl_idx(tbl_idx), .ent_port(ent_port),
    .ent_reg(ent_reg), .ent_value(ent_value), .req_valid(req_valid),
    .req_write(req_write), .req_dev(req_dev), .req_reg(req_reg),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .busy(busy), .done(done), .result(result)
  );

  // table storage with one cycle read latency
  logic [25:0] mem [MAXE];
  always_ff @(posedge clk) {ent_port, ent_reg, ent_value} <= mem[tbl_idx];

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit ended   = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "WDOG", "run did not finish", cyc, 150000);
      finish_run();
    end
  end

  // scoreboard queues
  item_t exp_q[$];
  string tag_q[$];
  logic [1:0] dn_q[$];
  string dn_tag_q[$];

  task automatic push(bit wr, logic [4:0] dev, logic [4:0] rg, logic [15:0] data, string tag);
    exp_q.push_back({wr, dev, rg, wr ? data : 16'h0});
    tag_q.push_back(tag);
  endtask

  // switch model
  logic [15:0] m_ctrl;
  bit m_act, m_tgt, m_rbusy;
  int m_lag, m_lag_left;
  bit m_no_en, m_no_dis, m_rst_stuck, m_err_en, m_ctl_err;
  logic [15:0] m_err_val;

  task automatic model_setup(int lag, bit no_en, bit no_dis, bit rst_stuck,
                             bit err_en, logic [15:0] err_val, bit ctl_err);
    m_ctrl = 16'h40A5; m_act = 1; m_tgt = 1; m_rbusy = 0; m_lag_left = 0;
    m_lag = lag; m_no_en = no_en; m_no_dis = no_dis; m_rst_stuck = rst_stuck;
    m_err_en = err_en; m_err_val = err_val; m_ctl_err = ctl_err;
  endtask

  // engine model and monitor share one negedge process
  int      pend = 0;
  item_t   pend_it;
  int      rsp_cyc = 0;
  bit      prev_sts = 0;
  int      done_seen = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (req_valid) begin
        item_t got;
        bit    is_sts;
        got    = {req_write, req_dev, req_reg, req_write ? req_wdata : 16'h0};
        is_sts = !req_write && req_dev == 5'h1B && req_reg == 5'h00;
        chk(pend == 0, "R13", "request while one outstanding", pend, 0);
        if (exp_q.size() == 0) begin
          chk(0, "R2", "unexpected request", got, 0);
        end else begin
          item_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(got == e, t, "request", got, e);
        end
        if (prev_sts && is_sts)
          chk(cyc - rsp_cyc == GAP + 2, "R9", "status read spacing", cyc - rsp_cyc, GAP + 2);
        prev_sts = is_sts;
      end
      if (done) begin
        chk(!busy, "R12", "busy with done", busy, 0);
        chk(cyc == rsp_cyc + 1, "R12", "done latency", cyc - rsp_cyc, 1);
        if (dn_q.size() == 0) begin
          chk(0, "R12", "unexpected done", result, 0);
        end else begin
          logic [1:0] ed;
          string t;
          ed = dn_q.pop_front();
          t  = dn_tag_q.pop_front();
          chk(result == ed, t, "result code", result, ed);
        end
        done_seen++;
        prev_sts = 0;
      end
    end
    // engine
    rsp_valid = 0;
    rsp_err   = 0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        rsp_valid = 1;
        rsp_cyc   = cyc;
        rsp_rdata = 16'h0;
        if (pend_it.wr) begin
          if (m_err_en && pend_it.data == m_err_val) rsp_err = 1;
          else if (pend_it.dev == 5'h1B && pend_it.rg == 5'h04) begin
            m_ctrl = pend_it.data & 16'h7FFF;
            m_lag_left = m_lag;
            if (pend_it.data[15]) begin
              m_rbusy = 1; m_act = 1; m_tgt = 1;
            end else m_tgt = pend_it.data[14];
          end
        end else if (pend_it.dev == 5'h1B && pend_it.rg == 5'h04) begin
          if (m_ctl_err) rsp_err = 1;
          rsp_rdata = m_ctrl;
        end else if (pend_it.dev == 5'h1B && pend_it.rg == 5'h00) begin
          if (m_lag_left > 0) m_lag_left--;
          else begin
            if (!((m_tgt && m_no_en) || (!m_tgt && m_no_dis))) m_act = m_tgt;
            m_rbusy = m_rst_stuck;
          end
          rsp_rdata = {m_act, m_act, 2'b00, m_rbusy, 11'h000};
        end
      end
    end
    if (!rst && req_valid) begin
      pend    = LAT;
      pend_it = {req_write, req_dev, req_reg, req_write ? req_wdata : 16'h0};
    end
  end

  function automatic int npolls(int lag, bit never);
    if (never || lag + 1 > MAXP) return MAXP;
    return lag + 1;
  endfunction

  task automatic expect_program(int cnt, int lag, int err_idx, bit no_en, bit no_dis, string dtag);
    logic [15:0] c;
    bit err;
    c = m_ctrl & 16'hBFFF;
    push(0, 5'h1B, 5'h04, 0, "R2");
    push(1, 5'h1B, 5'h04, c, "R3");
    for (int i = 0; i < npolls(lag, no_dis); i++) push(0, 5'h1B, 5'h00, 0, "R3");
    if (no_dis) begin
      dn_q.push_back(2'd2); dn_tag_q.push_back(dtag);
      return;
    end
    err = 0;
    for (int i = 0; i < cnt; i++) begin
      push(1, mem[i][25:21], mem[i][20:16], mem[i][15:0], "R4");
      if (i == err_idx) begin err = 1; break; end
    end
    push(0, 5'h1B, 5'h04, 0, "R5");
    push(1, 5'h1B, 5'h04, c | 16'h4000, "R5");
    for (int i = 0; i < npolls(lag, no_en); i++) push(0, 5'h1B, 5'h00, 0, "R5");
    dn_q.push_back(err ? 2'd1 : (no_en ? 2'd2 : 2'd0));
    dn_tag_q.push_back(dtag);
  endtask

  task automatic expect_reset(int lag, bit stuck, string dtag);
    push(0, 5'h1B, 5'h04, 0, "R10");
    push(1, 5'h1B, 5'h04, 16'hC400, "R10");
    for (int i = 0; i < npolls(lag, stuck); i++) push(0, 5'h1B, 5'h00, 0, "R10");
    dn_q.push_back(stuck ? 2'd2 : 2'd0);
    dn_tag_q.push_back(dtag);
  endtask

  task automatic run_cmd(bit rcmd, int cnt, bit spurious, string tag);
    int d0;
    d0 = done_seen;
    @(negedge clk);
    start = 1; cmd_reset = rcmd; entry_count = CW'(cnt);
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R2", "busy after start", busy, 1);
    if (spurious) begin
      repeat (4) @(negedge clk);
      start = 1; cmd_reset = 1; entry_count = CW'(1);
      @(negedge clk);
      start = 0;
    end
    while (done_seen == d0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, tag, "expected requests left over", exp_q.size(), 0);
    chk(!busy, tag, "busy after done", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < MAXE; i++)
      mem[i] = {5'(i + 1), 5'((i * 3) % 32), 16'(16'h1000 + i * 16'h0111)};
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy == 0, "R1", "busy after reset", busy, 0);
    chk(done == 0, "R1", "done after reset", done, 0);
    chk(req_valid == 0, "R1", "req_valid after reset", req_valid, 0);
    chk(result == 0, "R1", "result after reset", result, 0);
    chk(tbl_idx == 0, "R1", "tbl_idx after reset", tbl_idx, 0);

    // R3 R4 R5 R9: three entries, two lagging status reads per poll
    model_setup(2, 0, 0, 0, 0, 0, 0);
    expect_program(3, 2, -1, 0, 0, "R5");
    run_cmd(0, 3, 0, "R5");

    // R6: empty table
    model_setup(0, 0, 0, 0, 0, 0, 0);
    expect_program(0, 0, -1, 0, 0, "R6");
    run_cmd(0, 0, 0, "R6");

    // R7: write error on entry 2 of 5
    model_setup(1, 0, 0, 0, 1, mem[2][15:0], 0);
    expect_program(5, 1, 2, 0, 0, "R7");
    run_cmd(0, 5, 0, "R7");

    // R8: enable never takes effect
    model_setup(0, 1, 0, 0, 0, 0, 0);
    expect_program(2, 0, -1, 1, 0, "R8");
    run_cmd(0, 2, 0, "R8");

    // R8: disable never takes effect
    model_setup(0, 0, 1, 0, 0, 0, 0);
    expect_program(2, 0, -1, 0, 1, "R8");
    run_cmd(0, 2, 0, "R8");

    // R2: full table with a second start while busy
    model_setup(0, 0, 0, 0, 0, 0, 0);
    expect_program(MAXE, 0, -1, 0, 0, "R4");
    run_cmd(0, MAXE, 1, "R2");

    // R10: reset with one lagging status read
    model_setup(1, 0, 0, 0, 0, 0, 0);
    expect_reset(1, 0, "R10");
    run_cmd(1, 0, 0, "R10");

    // R10 R8: reset never completes
    model_setup(0, 0, 0, 1, 0, 0, 0);
    expect_reset(0, 1, "R8");
    run_cmd(1, 0, 0, "R8");

    // R11: control read error ends the command
    model_setup(0, 0, 0, 0, 0, 0, 1);
    push(0, 5'h1B, 5'h04, 0, "R11");
    dn_q.push_back(2'd1); dn_tag_q.push_back("R11");
    run_cmd(0, 2, 0, "R11");

    finish_run();
  end
endmodule